// File: doc/BRIEF.md
# Byte-Serial Masked AES Column Engine

This block runs one AES-128 round transformation on one state column at a time. The state lives in an external 16-word by 16-bit memory. Each word carries one real state byte in one half and a filler byte in the other half. The engine works on 8-bit values only and does no key expansion.

Once started for a column, the engine spends four cycles reading. In each read cycle it fetches a word from an address that already folds in the row rotation. It takes the real half, substitutes it through a combinational S-box, and parks the result in a four-byte accumulator. The slot is rotated by a caller-supplied shuffle offset.

The engine then spends four cycles writing. In each write cycle it produces one column-mixed byte, XORs in the matching round-key byte, and writes it into the half that does not currently hold the real byte. The word keeps its other half, so bytes that later columns still need are never overwritten. Each full round therefore moves the real data to the opposite half, and the caller flips the half selector every round. The write order follows the shuffle offset. Round sequencing and random-number generation belong to the caller.

Top module: `aes_col_engine`

## Requirements
- R1: While rst_ni is low and after it is released, busy_o, done_o and mem_we_o are 0, and mem_addr_o, mem_be_o and mem_wdata_o are all zero.
- R2: Read cycle j (j = 0..3) of a column operation on column c drives mem_addr_o = 4*((c+j) mod 4) + j. For column 0 this gives addresses 0, 5, 10 and 15.
- R3: The byte fetched in read cycle j is mem_rdata_i[7:0] when the half selector real_hi_i was 0 at start, and mem_rdata_i[15:8] when it was 1. That byte is replaced by its standard AES S-box value (00->63, 01->7C, 53->ED).
- R4: With s_r the substituted byte of row r, the byte written for row k is 2*s_k ^ 3*s_(k+1) ^ s_(k+2) ^ s_(k+3) ^ rkey_i[8k+7:8k]. Indices are taken mod 4 and products are in GF(2^8) with polynomial 0x11B. rkey_i is sampled at start.
- R5: Each write goes to address 4*c + k and touches exactly one half. mem_be_o bit 0 enables the low half and bit 1 the high half. The written half is the high one when real_hi_i was 0, and the low one otherwise. The result sits in the enabled half and the other half of mem_wdata_o is zero.
- R6: Write cycle s (s = 0..3) writes row k = (s - shuf_i) mod 4, where shuf_i is sampled at start.
- R7: A column operation takes eight cycles after the start edge: four reads, then four consecutive writes. done_o is high exactly in the fourth write cycle, and busy_o falls on the next edge.
- R8: start_i is ignored while busy_o is high. A column operation already under way is not disturbed by it.
- R9: While busy_o is low, mem_we_o, mem_be_o, mem_addr_o and mem_wdata_o are held at zero (operand isolation).
- R10: Running columns 0..3 with one half selector and round key updates the state in place to the standard AES round output. Running them again with the selector flipped and the next round key yields the round after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a column operation (taken only when idle) |
| col_i | input | 2 | Target column index |
| real_hi_i | input | 1 | 1: real bytes are in the upper half this round |
| shuf_i | input | 2 | Random accumulator slot offset |
| rkey_i | input | 32 | Round-key bytes of the column, row r at bits 8r+7:8r |
| mem_addr_o | output | 4 | State memory word address |
| mem_rdata_i | input | 16 | State memory read data (combinational read) |
| mem_we_o | output | 1 | State memory write strobe |
| mem_be_o | output | 2 | Half enables: bit 0 low byte, bit 1 high byte |
| mem_wdata_o | output | 16 | State memory write data |
| busy_o | output | 1 | Column operation in progress |
| done_o | output | 1 | Final write cycle of a column |

## Verification
The hardest corner is in-place update across a whole round. If the engine wrote the full word, or picked the wrong half, a later column would read an already-mixed byte, and the round result would no longer match the standard vectors. The bench runs two consecutive rounds with the half selector flipped to expose this.

Shuffle offsets are swept over all four values. An engine that mapped accumulator slots back to rows incorrectly would write correct-looking bytes to the wrong addresses, or in a fixed order.

A start pulse is injected mid-operation with different operands. A design that retriggered on it would stretch busy_o or corrupt the write stream.

Idle cycles are watched for any non-zero address or data, which is where missing operand isolation shows up.

// File: rtl/aes_col_pkg.sv
package aes_col_pkg;
  localparam int BYTE_W = 8;
  localparam int NROW   = 4;
  localparam int ROW_W  = $clog2(NROW);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 2 * ROW_W;
  localparam int COLK_W = NROW * BYTE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_st_e;

  function automatic logic [7:0] gf_x2(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254, zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] p;
    logic [7:0] e;
    r = 8'h01;
    p = x;
    e = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] v;
    v = gf_inv(x);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_col_sbox.sv
module aes_col_sbox
  import aes_col_pkg::*;
(
  input  logic              en_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic [BYTE_W-1:0] dout_o
);
  logic [BYTE_W-1:0] iso;
  assign iso    = en_i ? din_i : '0;
  assign dout_o = en_i ? sub_byte(iso) : '0;
endmodule

// File: rtl/aes_col_mix.sv
module aes_col_mix
  import aes_col_pkg::*;
(
  input  logic              en_i,
  input  logic [COLK_W-1:0] rows_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [BYTE_W-1:0] key_i,
  output logic [BYTE_W-1:0] dout_o
);
  logic [COLK_W-1:0] rows;
  logic [BYTE_W-1:0] key;
  logic [BYTE_W-1:0] b [NROW];

  assign rows = en_i ? rows_i : '0;
  assign key  = en_i ? key_i  : '0;

  for (genvar n = 0; n < NROW; n++) begin : g_pick
    logic [ROW_W-1:0] idx;
    assign idx  = row_i + ROW_W'(n);
    assign b[n] = rows[{idx, 3'b000} +: BYTE_W];
  end

  assign dout_o = gf_x2(b[0]) ^ gf_x2(b[1]) ^ b[1] ^ b[2] ^ b[3] ^ key;
endmodule

// File: rtl/aes_col_engine.sv
module aes_col_engine
  import aes_col_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        col_i,
  input  logic              real_hi_i,
  input  logic [1:0]        shuf_i,
  input  logic [31:0]       rkey_i,
  output logic [3:0]        mem_addr_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              mem_we_o,
  output logic [1:0]        mem_be_o,
  output logic [15:0]       mem_wdata_o,
  output logic              busy_o,
  output logic              done_o
);
  eng_st_e           st_q;
  logic [ROW_W-1:0]  cnt_q;
  logic [ROW_W-1:0]  col_q;
  logic [ROW_W-1:0]  off_q;
  logic              hi_q;
  logic [COLK_W-1:0] key_q;
  logic [BYTE_W-1:0] acc_q [NROW];

  logic              rd_act, wr_act;
  logic [ROW_W-1:0]  rd_col, wr_row, rd_slot;
  logic [BYTE_W-1:0] rd_byte, sb_out, mix_out, mix_key;
  logic [COLK_W-1:0] mix_in;

  assign rd_act  = (st_q == ST_RD);
  assign wr_act  = (st_q == ST_WR);
  assign rd_col  = col_q + cnt_q;       // row rotation folded into address
  assign rd_slot = cnt_q + off_q;       // shuffled accumulator slot
  assign wr_row  = cnt_q - off_q;       // undo shuffle on write-back
  assign rd_byte = hi_q ? mem_rdata_i[WORD_W-1:BYTE_W] : mem_rdata_i[BYTE_W-1:0];
  assign mix_key = key_q[{wr_row, 3'b000} +: BYTE_W];

  aes_col_sbox u_sbox (
    .en_i   (rd_act),
    .din_i  (rd_byte),
    .dout_o (sb_out)
  );

  for (genvar k = 0; k < NROW; k++) begin : g_rows
    logic [ROW_W-1:0] sl;
    assign sl = ROW_W'(k) + off_q;
    assign mix_in[k*BYTE_W +: BYTE_W] = acc_q[sl];
  end

  aes_col_mix u_mix (
    .en_i   (wr_act),
    .rows_i (mix_in),
    .row_i  (wr_row),
    .key_i  (mix_key),
    .dout_o (mix_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      col_q <= '0;
      off_q <= '0;
      hi_q  <= 1'b0;
      key_q <= '0;
      for (int i = 0; i < NROW; i++) acc_q[i] <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RD;
          cnt_q <= '0;
          col_q <= col_i;
          off_q <= shuf_i;
          hi_q  <= real_hi_i;
          key_q <= rkey_i;
        end
        ST_RD: begin
          acc_q[rd_slot] <= sb_out;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == ROW_W'(NROW - 1)) st_q <= ST_WR;
        end
        ST_WR: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == ROW_W'(NROW - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr_o  = '0;
    mem_we_o    = 1'b0;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    if (rd_act) begin
      mem_addr_o = {rd_col, cnt_q};
    end else if (wr_act) begin
      mem_addr_o  = {col_q, wr_row};
      mem_we_o    = 1'b1;
      mem_be_o    = hi_q ? 2'b01 : 2'b10;
      mem_wdata_o = hi_q ? {{BYTE_W{1'b0}}, mix_out} : {mix_out, {BYTE_W{1'b0}}};
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = wr_act && (cnt_q == ROW_W'(NROW - 1));
endmodule

// File: rtl/aes_col_engine_chk.sv
module aes_col_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [1:0]  col_i,
  input logic        real_hi_i,
  input logic [1:0]  shuf_i,
  input logic [31:0] rkey_i,
  input logic [3:0]  mem_addr_o,
  input logic [15:0] mem_rdata_i,
  input logic        mem_we_o,
  input logic [1:0]  mem_be_o,
  input logic [15:0] mem_wdata_o,
  input logic        busy_o,
  input logic        done_o
);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && mem_be_o == 2'b00 && mem_addr_o == 4'h0 && mem_wdata_o == 16'h0));

  a_r5_one_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $countones(mem_be_o) == 1);

  a_r7_done_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mem_we_o && busy_o));

  a_r7_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r8_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  a_r7_write_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !done_o) |=> mem_we_o);

  a_r5_half_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !done_o) |=> $stable(mem_be_o));

  a_r5_col_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !done_o) |=> mem_addr_o[3:2] == $past(mem_addr_o[3:2]));
endmodule

bind aes_col_engine aes_col_engine_chk u_chk (.*);

// File: tb/tb_aes_col_engine.sv
module tb_aes_col_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start, real_hi;
  logic [1:0]  col, shuf;
  logic [31:0] rkey;
  logic [3:0]  mem_addr;
  logic [15:0] mem_rdata, mem_wdata;
  logic        mem_we, busy, done;
  logic [1:0]  mem_be;

  logic [15:0] mem [16];
  logic        ld_en;
  logic [3:0]  ld_addr;
  logic [15:0] ld_data;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [3:0]  a;
    logic [1:0]  be;
    logic [15:0] d;
    logic        last;
  } wr_t;
  wr_t        wq[$];
  logic [3:0] rq[$];

  aes_col_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .col_i(col), .real_hi_i(real_hi),
    .shuf_i(shuf), .rkey_i(rkey), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .busy_o(busy), .done_o(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) begin
      if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[0]) r = r ^ a;
      a = (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
      b = b >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] b_sbox(input logic [7:0] x);
    logic [7:0] v = 8'h00;
    logic [7:0] s;
    for (int y = 1; y < 256; y++)
      if (b_mul(x, 8'(y)) == 8'h01) v = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return s;
  endfunction

  // monitor: compares read addresses and write items against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !mem_we) begin
        if (rq.size() == 0) chk("R2 unexpected read", 32'(mem_addr), 32'hffff);
        else chk("R2 read address", 32'(mem_addr), 32'(rq.pop_front()));
      end
      if (mem_we) begin
        if (wq.size() == 0) chk("R7 unexpected write", 32'(mem_addr), 32'hffff);
        else begin
          wr_t e;
          e = wq.pop_front();
          chk("R5/R6 write address", 32'(mem_addr), 32'(e.a));
          chk("R5 half enable", 32'(mem_be), 32'(e.be));
          chk("R3/R4 write data", 32'(mem_wdata), 32'(e.d));
          chk("R7 done flag", 32'(done), 32'(e.last));
        end
      end
    end
  end

  task automatic load_word(input logic [3:0] a, input logic [15:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " R7 busy low"}, 32'(busy), 0);
    chk({tag, " R9 isolated outputs"}, {mem_wdata, 11'(mem_addr), mem_be, mem_we, done}, 0);
    chk({tag, " R7 queues drained"}, 32'(wq.size() + rq.size()), 0);
  endtask

  task automatic run_col(input logic [1:0] c, input logic hi, input logic [1:0] off,
                         input logic [31:0] key, input bit poke);
    logic [7:0] s [4];
    for (int r = 0; r < 4; r++) begin
      logic [3:0]  a;
      logic [15:0] w;
      a = {2'(c + 2'(r)), 2'(r)};
      w = mem[a];
      s[r] = b_sbox(hi ? w[15:8] : w[7:0]);
      rq.push_back(a);
    end
    for (int q = 0; q < 4; q++) begin
      wr_t        e;
      logic [1:0] k;
      logic [7:0] m;
      k = 2'(q) - off;
      m = b_mul(8'h02, s[k]) ^ b_mul(8'h03, s[2'(k + 1)]) ^ s[2'(k + 2)] ^ s[2'(k + 3)]
          ^ key[{k, 3'b000} +: 8];
      e.a = {c, k};
      e.be = hi ? 2'b01 : 2'b10;
      e.d = hi ? {8'h00, m} : {m, 8'h00};
      e.last = (q == 3);
      wq.push_back(e);
    end
    col = c; real_hi = hi; shuf = off; rkey = key; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R8: second start mid-operation with other operands must be ignored
      @(negedge clk);
      col = c + 2'd1; real_hi = ~hi; shuf = off + 2'd1; rkey = ~key; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
    end else begin
      repeat (8) @(negedge clk);
    end
    check_idle(poke ? "R8" : "col");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] st1, st2, st3, k1, k2;
    st1 = 128'h193de3bea0f4e22b9ac68d2ae9f84808;
    st2 = 128'ha49c7ff2689f352b6b5bea43026a5049;
    st3 = 128'haa8f5f0361dde3ef82d24ad26832469a;
    k1  = 128'ha0fafe1788542cb123a339392a6c7605;
    k2  = 128'hf2c295f27a96b9435935807a7359f67f;
    rst_n = 1'b0; start = 1'b0; col = '0; real_hi = 1'b0; shuf = '0; rkey = '0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset outputs", {mem_wdata, 11'(mem_addr), mem_be, mem_we, busy, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {mem_wdata, 11'(mem_addr), mem_be, mem_we, busy, done}, 0);

    // R2/R3/R4/R6: random contents, every column, both halves, all offsets
    for (int t = 0; t < 16; t++) begin
      for (int a = 0; a < 16; a++) load_word(4'(a), 16'($urandom));
      run_col(2'(t), t[2], 2'(t >> 2), $urandom, t == 5 || t == 11);
    end

    // R3 corner bytes: zero, one and 0x53 in the real half of column 0 row words
    load_word(4'd0, 16'hab00); load_word(4'd5, 16'hcd01);
    load_word(4'd10, 16'hef53); load_word(4'd15, 16'h12ff);
    run_col(2'd0, 1'b0, 2'd3, 32'h0, 1'b0);

    // R10: two full rounds in place against standard round vectors
    for (int i = 0; i < 16; i++) load_word(4'(i), {8'($urandom), st1[127 - 8*i -: 8]});
    for (int c = 0; c < 4; c++) begin
      logic [31:0] kc;
      for (int r = 0; r < 4; r++) kc[8*r +: 8] = k1[127 - 8*(4*c + r) -: 8];
      run_col(2'(c), 1'b0, 2'(c + 1), kc, 1'b0);
    end
    for (int i = 0; i < 16; i++) begin
      chk("R10 round one in upper half", 32'(mem[i][15:8]), 32'(st2[127 - 8*i -: 8]));
      chk("R5 lower half untouched", 32'(mem[i][7:0]), 32'(st1[127 - 8*i -: 8]));
    end
    for (int c = 0; c < 4; c++) begin
      logic [31:0] kc;
      for (int r = 0; r < 4; r++) kc[8*r +: 8] = k2[127 - 8*(4*c + r) -: 8];
      run_col(2'(c), 1'b1, 2'(3 - c), kc, c == 2);
    end
    for (int i = 0; i < 16; i++) begin
      chk("R10 round two in lower half", 32'(mem[i][7:0]), 32'(st3[127 - 8*i -: 8]));
      chk("R5 upper half untouched", 32'(mem[i][15:8]), 32'(st2[127 - 8*i -: 8]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule